// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block is a programmable interval timer with three channels, reached through a byte-wide window of four addresses. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. Software writes a control byte to choose a channel, a byte-access mode shared by all data ports, and an operating mode for the chosen channel. It then writes 16-bit reload values one byte at a time through the data ports. Stored reload bytes and the last control byte can be read back.

Only channel 0 counts. Each `tick_en` strobe decrements it. When it reaches terminal count it reloads its divisor and adds one to a saturating pending-event counter. When channel 0 is in interrupt-on-terminal-count mode, a nonzero pending count holds `irq` high. Each acknowledge cycle consumes one pending event. Channels 1 and 2 store their settings and drive nothing else.

Top module: `interval_timer`

## Requirements
- R1: After reset, `irq` and `cfg_err` are low, the control port reads 0x00, and all channels are in rate-generator mode (mode 2).
- R2: Control byte bits 7:6 choose the channel, and the value 3 acts as channel 0. Bits 3:1 become that channel's mode: 0 is interrupt on terminal count, 2 is rate generator and 3 is square wave. Bits 5:4 set the access mode: 01 is low byte, 10 is high byte, 11 is low then high, and 00 is no data access.
- R3: A low-byte write replaces reload bits 7:0 and keeps 15:8. A high-byte write replaces bits 15:8 and keeps 7:0. A data-port read returns the stored low or high byte, following the access mode.
- R4: In low-then-high mode, any read or write of a data port clears control bit 4. All later accesses therefore act on the high byte until a new control byte is written.
- R5: A read of the control port returns the stored control byte, including any bit 4 cleared under R4.
- R6: `cfg_err` equals bit 0 (decimal counting request) of the last control byte written.
- R7: A high-byte write to channel 0 that completes a nonzero value N restarts the count. A terminal-count event then occurs on exactly every Nth `tick_en` strobe.
- R8: A high-byte write to channel 0 that completes the value zero stops event generation. A low-byte write never starts or restarts the count.
- R9: Each clock cycle in which `irq_ack` is high removes one pending event if the count is nonzero. An acknowledge at zero has no effect.
- R10: The pending-event count saturates at 255.
- R11: A control write that selects channel 0 (select value 0 or 3) clears the pending count. A control write that selects channel 1 or 2 leaves it unchanged.
- R12: `irq` is high only while channel 0 is in mode 0 and the pending count is above zero. In modes 2 and 3 it stays low.
- R13: When the access mode is 00, data writes are ignored and data reads return 0x00. Settings of channels 1 and 2 never affect `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0-2 data ports, 3 control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| tick_en | input | 1 | Count strobe for channel 0 |
| irq_ack | input | 1 | Consumes one pending event per high cycle |
| irq | output | 1 | Level interrupt request from channel 0 |
| cfg_err | output | 1 | Unsupported decimal counting requested |

## Verification
A wrong count phase in channel 0 shows on `irq` at the first terminal-count event: the line rises one strobe early or late. A wrong pending count stays hidden until enough acknowledges have been given to drain it. The bench therefore pins the count by draining it exactly and checks that `irq` falls on the final acknowledge and not one before. A stale access field shows on the very next data-port read or on a control-port read.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int PEND_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_en,
  input  logic       irq_ack,
  output logic       irq,
  output logic       cfg_err
);

  localparam int             NCH        = 3;
  localparam logic [2:0]     MODE_TCINT = 3'd0;
  localparam logic [2:0]     MODE_RATE  = 3'd2;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [7:0]        ctrl_q;
  logic [2:0]        mode_q [NCH];
  logic [15:0]       rld_q  [NCH];
  logic [15:0]       cnt_q;
  logic              run_q;
  logic [PEND_W-1:0] pend_q;
  logic [15:0]       rd_val;

  wire       ctrl_wr  = bus_sel & bus_wr & (bus_addr == 2'd3);
  wire       data_acc = bus_sel & (bus_addr != 2'd3);
  wire       data_wr  = data_acc & bus_wr;
  wire [1:0] acc_mode = ctrl_q[5:4];
  wire       lo_acc   = acc_mode[0];
  wire       hi_acc   = (acc_mode == 2'b10);
  wire [1:0] wsel     = (bus_wdata[7:6] == 2'd3) ? 2'd0 : bus_wdata[7:6];
  wire       pend_clr = ctrl_wr & (wsel == 2'd0);
  wire       start0   = data_wr & hi_acc & (bus_addr == 2'd0);
  wire [15:0] new0    = {bus_wdata, rld_q[0][7:0]};
  wire       tc_ev    = tick_en & run_q & (cnt_q == 16'd1) & ~start0;
  wire       ack_ok   = irq_ack & (pend_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= 8'h00;
    else if (ctrl_wr)
      ctrl_q <= bus_wdata;
    else if (data_acc && acc_mode == 2'b11)
      ctrl_q[4] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        mode_q[c] <= MODE_RATE;
        rld_q[c]  <= 16'h0000;
      end else begin
        if (ctrl_wr && wsel == 2'(c))
          mode_q[c] <= bus_wdata[3:1];
        if (data_wr && bus_addr == 2'(c)) begin
          if (lo_acc)
            rld_q[c][7:0] <= bus_wdata;
          else if (hi_acc)
            rld_q[c][15:8] <= bus_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= 16'h0000;
      run_q <= 1'b0;
    end else if (start0) begin
      cnt_q <= new0;
      run_q <= (new0 != 16'h0000);
    end else if (tick_en && run_q) begin
      if (cnt_q == 16'd1) begin
        cnt_q <= rld_q[0];
        if (rld_q[0] == 16'h0000)
          run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 16'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pend_clr)
      pend_q <= '0;
    else if (tc_ev && !ack_ok && pend_q != PEND_MAX)
      pend_q <= pend_q + 1'b1;
    else if (ack_ok && !tc_ev)
      pend_q <= pend_q - 1'b1;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    rd_val = rld_q[0];
      2'd1:    rd_val = rld_q[1];
      default: rd_val = rld_q[2];
    endcase
    bus_rdata = 8'h00;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == 2'd3)
        bus_rdata = ctrl_q;
      else if (lo_acc)
        bus_rdata = rd_val[7:0];
      else if (hi_acc)
        bus_rdata = rd_val[15:8];
    end
  end

  assign irq     = (mode_q[0] == MODE_TCINT) && (pend_q != '0);
  assign cfg_err = ctrl_q[0];

  AST_CLR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> pend_q == '0); // R11
  AST_ACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !tc_ev && !pend_clr) |=> pend_q == $past(pend_q) - 1'b1); // R9
  AST_PEND_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == PEND_MAX && !ack_ok && !pend_clr) |=> pend_q == PEND_MAX); // R10
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tc_ev |=> cnt_q == $past(rld_q[0])); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start0) |=> $stable(cnt_q)); // R8

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tick_en = 1'b0, irq_ack = 1'b0;
  logic       irq, cfg_err;

  int n_chk = 0, n_pass = 0;
  logic [7:0] rv;

  interval_timer i_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq_ack(irq_ack), .irq(irq), .cfg_err(cfg_err));

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act == exp) n_pass++;
    else $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic acks(input int n);
    @(negedge clk);
    irq_ack = 1'b1;
    repeat (n) @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", irq, 0);
    check("R1 cfg_err", cfg_err, 0);
    rd(2'd3, rv); check("R1 ctrl", rv, 8'h00);
  endtask

  task automatic t_bytes();
    wr(3, 8'h50); wr(1, 8'h34);
    wr(3, 8'h60); wr(1, 8'h12);
    rd(1, rv); check("R3 high byte", rv, 8'h12);
    wr(3, 8'h50); rd(1, rv); check("R3 low byte kept", rv, 8'h34);
    wr(3, 8'h40); wr(1, 8'hFF);
    rd(1, rv); check("R13 read in mode 00", rv, 8'h00);
    wr(3, 8'h50); rd(1, rv); check("R13 write ignored", rv, 8'h34);
    wr(3, 8'hA0); wr(2, 8'hAB);
    wr(3, 8'h90); rd(2, rv); check("R3 ch2 low untouched", rv, 8'h00);
    wr(3, 8'hA0); rd(2, rv); check("R3 ch2 high", rv, 8'hAB);
    check("R13 irq", irq, 0);
  endtask

  task automatic t_seq();
    wr(3, 8'hB6); rd(3, rv); check("R5 ctrl readback", rv, 8'hB6);
    wr(2, 8'hCD); rd(3, rv); check("R4 bit4 cleared", rv, 8'hA6);
    wr(2, 8'hEF); wr(2, 8'h11);
    wr(3, 8'h90); rd(2, rv); check("R4 low once", rv, 8'hCD);
    wr(3, 8'hA0); rd(2, rv); check("R4 later writes high", rv, 8'h11);
    wr(3, 8'hB0); rd(2, rv); check("R4 first read low", rv, 8'hCD);
    rd(3, rv); check("R4 read clears bit4", rv, 8'hA0);
    rd(2, rv); check("R4 second read high", rv, 8'h11);
  endtask

  task automatic t_bcd();
    wr(3, 8'h51); check("R6 set", cfg_err, 1);
    wr(3, 8'h50); check("R6 clear", cfg_err, 0);
  endtask

  task automatic t_period();
    wr(3, 8'h30); wr(0, 8'h05); wr(0, 8'h00);
    ticks(4); check("R7 before Nth", irq, 0);
    ticks(1); check("R7 at Nth", irq, 1);
    acks(1); check("R9 ack", irq, 0);
    ticks(4); check("R7 repeat before", irq, 0);
    ticks(1); check("R7 repeat", irq, 1);
    acks(1);
  endtask

  task automatic t_select3();
    ticks(5); check("R7 pending", irq, 1);
    wr(3, 8'hD0); check("R11 select 3 clears", irq, 0);
    ticks(5); check("R2 select 3 -> ch0 mode 0", irq, 1);
    wr(3, 8'h50); check("R11 ch1 keeps", irq, 1);
    wr(3, 8'h90); check("R11 ch2 keeps", irq, 1);
  endtask

  task automatic t_ack();
    ticks(10);
    acks(2); check("R9 two of three", irq, 1);
    acks(1); check("R9 drained", irq, 0);
    acks(1);
    ticks(5); check("R9 no underflow", irq, 1);
    acks(1); check("R9 single", irq, 0);
  endtask

  task automatic t_sat();
    wr(3, 8'h30); wr(0, 8'h01); wr(0, 8'h00);
    ticks(300);
    acks(254); check("R10 one left", irq, 1);
    acks(1); check("R10 saturated at 255", irq, 0);
  endtask

  task automatic t_modes();
    wr(3, 8'h34); ticks(3); check("R12 rate gen", irq, 0);
    wr(3, 8'h36); ticks(3); check("R12 square wave", irq, 0);
    wr(3, 8'h30); check("R12 mode 0 after clear", irq, 0);
    ticks(1); check("R12 mode 0", irq, 1);
    acks(1);
  endtask

  task automatic t_stop();
    wr(3, 8'h30); wr(0, 8'h00); wr(0, 8'h00);
    ticks(50); check("R8 zero stops", irq, 0);
    wr(3, 8'h10); wr(0, 8'h03);
    ticks(10); check("R8 low write no start", irq, 0);
    wr(3, 8'h20); wr(0, 8'h00);
    ticks(2); check("R7 restart before", irq, 0);
    ticks(1); check("R7 restart at 3", irq, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_seq();
    t_bcd();
    t_period();
    t_select3();
    t_ack();
    t_sat();
    t_modes();
    t_stop();
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule